// File: doc/BRIEF.md
# Time-Division Bus Slot and Round Sequencer

This block produces the bus-access timetable that one node follows on a shared, time-triggered bus. A cycle counter cuts time into slots of equal, configurable length. A fixed table, set by a parameter, names the node that owns each slot position. The block also tracks which slot of the round is active and which round of the cluster cycle is active. Every round repeats the same slot timing. The round number is output as a frame-select index, so the host can load different frame content for each round while the timing pattern stays the same.

The node raises `run_en` to join the schedule. The sequencer then counts through the slots of a round. After the last slot it starts the next round, and after the last configured round it goes back to round 0, which begins a new cluster cycle. A transmit enable stays high for the whole of every slot that the local node owns. Single-cycle markers flag the first cycle of each slot, each round and each cluster cycle. A configuration with fewer than four slots per round, more slots or rounds than the build supports, zero rounds or a zero slot length is refused. While it is refused, the sequencer stays idle.

Top module: `tdma_sequencer`

## Requirements
- R1: While `rst` is high, `run_en` is low or the configuration is refused, the block is idle: `slot_idx`=0, `round_idx`=0, and `tx_en`, `slot_start`, `round_start`, `cycle_start` are all 0.
- R2: The first clock edge that samples `run_en` high with a legal configuration starts the schedule. In the next cycle, `slot_start`, `round_start` and `cycle_start` are all 1, with `slot_idx`=0 and `round_idx`=0.
- R3: Every slot lasts exactly `cfg_slot_len` cycles. `slot_start` is 1 only in the first cycle of each slot.
- R4: `slot_idx` counts 0, 1, … `cfg_slots`-1 and then returns to 0. `round_start` is 1 only in the first cycle of slot 0.
- R5: `round_idx`, which is the frame-select index, goes up by one at each new round and returns to 0 after round `cfg_rounds`-1. `cycle_start` is 1 only in the first cycle of slot 0 of round 0.
- R6: `tx_en` is 1 in every cycle of a slot whose owner equals `local_id`, and 0 in every other cycle. The owner of slot s is bits [s*NODE_W +: NODE_W] of `OWNER_MAP`.
- R7: When the owner map has distinct entries, exactly one node ID has `tx_en` high in any running cycle.
- R8: `cfg_err` is 1 in the same cycle in which any of these holds: `cfg_slots` < 4, `cfg_slots` > MAX_SLOTS, `cfg_rounds` = 0, `cfg_rounds` > MAX_ROUNDS, or `cfg_slot_len` = 0. From the next cycle the schedule is held idle.
- R9: The output sequence of every cluster cycle is identical to that of the one before it.
- R10: When `run_en` is dropped mid-run, the block is idle in the next cycle. A later rise restarts from slot 0 of round 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Join and follow the schedule while high |
| local_id | input | NODE_W | ID of this node |
| cfg_slot_len | input | LEN_W | Cycles per slot |
| cfg_slots | input | clog2(MAX_SLOTS+1) | Slots per round |
| cfg_rounds | input | clog2(MAX_ROUNDS+1) | Rounds per cluster cycle |
| slot_idx | output | clog2(MAX_SLOTS) | Current slot position |
| round_idx | output | clog2(MAX_ROUNDS) | Current round, used as frame select |
| tx_en | output | 1 | Local node owns the current slot |
| slot_start | output | 1 | First cycle of a slot |
| round_start | output | 1 | First cycle of a round |
| cycle_start | output | 1 | First cycle of a cluster cycle |
| cfg_err | output | 1 | Configuration refused |

## Verification
The assertions assume that `local_id` and the three configuration inputs stay fixed while the schedule runs. They are changed only in one of two ways: to a refused value, which stops the schedule, or while `run_en` is low. The stimulus follows this rule. Every reconfiguration happens with the enable dropped, apart from deliberate switches to refused configurations. The bench drives a set of peer instances, one per node ID, from the same inputs. In these peers the ownership claim is a property of the whole bus rather than of a single port.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

  localparam int unsigned MIN_NODES = 4;

  function automatic logic cfg_legal(int unsigned slots, int unsigned rounds,
                                     int unsigned len, int unsigned max_slots,
                                     int unsigned max_rounds);
    return (slots >= MIN_NODES) && (slots <= max_slots) &&
           (rounds >= 1) && (rounds <= max_rounds) && (len >= 1);
  endfunction

  function automatic int unsigned wrap_inc(int unsigned v, int unsigned limit);
    return (v + 1 >= limit) ? 0 : v + 1;
  endfunction

  function automatic logic [1023:0] ident_map(int unsigned n, int unsigned w);
    logic [1023:0] m;
    m = '0;
    for (int unsigned i = 0; i < n; i++)
      for (int unsigned b = 0; b < w; b++)
        m[i*w + b] = i[b];
    return m;
  endfunction

endpackage

// File: rtl/tdma_cfg_check.sv
module tdma_cfg_check #(
  parameter int LEN_W       = 16,
  parameter int SLOT_CNT_W  = 4,
  parameter int ROUND_CNT_W = 4,
  parameter int MAX_SLOTS   = 8,
  parameter int MAX_ROUNDS  = 8
) (
  input  logic [LEN_W-1:0]       cfg_slot_len,
  input  logic [SLOT_CNT_W-1:0]  cfg_slots,
  input  logic [ROUND_CNT_W-1:0] cfg_rounds,
  output logic                   cfg_ok
);
  always_comb
    cfg_ok = tdma_pkg::cfg_legal(32'(cfg_slots), 32'(cfg_rounds), 32'(cfg_slot_len),
                                 MAX_SLOTS, MAX_ROUNDS);
endmodule

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [LEN_W-1:0] cfg_slot_len,
  output logic             running,
  output logic             slot_first,
  output logic             slot_end
);
  logic [LEN_W-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      running <= 1'b0;
      tick_q  <= '0;
    end else if (!running) begin
      running <= 1'b1;
      tick_q  <= '0;
    end else if (slot_end) begin
      tick_q  <= '0;
    end else begin
      tick_q  <= tick_q + 1'b1;
    end
  end

  always_comb begin
    slot_first = running && (tick_q == '0);
    slot_end   = running && (({1'b0, tick_q} + 1'b1) >= {1'b0, cfg_slot_len});
  end
endmodule

// File: rtl/tdma_position.sv
module tdma_position #(
  parameter int SLOT_IDX_W  = 3,
  parameter int ROUND_IDX_W = 3,
  parameter int SLOT_CNT_W  = 4,
  parameter int ROUND_CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   active,
  input  logic                   running,
  input  logic                   slot_end,
  input  logic [SLOT_CNT_W-1:0]  cfg_slots,
  input  logic [ROUND_CNT_W-1:0] cfg_rounds,
  output logic [SLOT_IDX_W-1:0]  slot_q,
  output logic [ROUND_IDX_W-1:0] round_q,
  output logic                   slot_wrap,
  output logic                   round_wrap
);
  logic [SLOT_IDX_W-1:0]  slot_nx;
  logic [ROUND_IDX_W-1:0] round_nx;

  always_comb begin
    slot_nx    = SLOT_IDX_W'(tdma_pkg::wrap_inc(32'(slot_q), 32'(cfg_slots)));
    round_nx   = ROUND_IDX_W'(tdma_pkg::wrap_inc(32'(round_q), 32'(cfg_rounds)));
    slot_wrap  = (32'(slot_q) + 1) >= 32'(cfg_slots);
    round_wrap = (32'(round_q) + 1) >= 32'(cfg_rounds);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      slot_q  <= '0;
      round_q <= '0;
    end else if (running && slot_end) begin
      slot_q <= slot_nx;
      if (slot_wrap) round_q <= round_nx;
    end
  end
endmodule

// File: rtl/tdma_owner_lookup.sv
module tdma_owner_lookup #(
  parameter int MAX_SLOTS  = 8,
  parameter int NODE_W     = 4,
  parameter int SLOT_IDX_W = 3,
  parameter logic [MAX_SLOTS*NODE_W-1:0] OWNER_MAP = '0
) (
  input  logic [SLOT_IDX_W-1:0] slot_idx,
  input  logic [NODE_W-1:0]     local_id,
  output logic                  is_mine
);
  logic [MAX_SLOTS-1:0] match;

  for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
    assign match[g] = (OWNER_MAP[g*NODE_W +: NODE_W] == local_id) &&
                      (32'(slot_idx) == g);
  end

  assign is_mine = |match;
endmodule

// File: rtl/tdma_sequencer.sv
module tdma_sequencer #(
  parameter int NODE_W     = 4,
  parameter int LEN_W      = 16,
  parameter int MAX_SLOTS  = 8,
  parameter int MAX_ROUNDS = 8,
  parameter logic [MAX_SLOTS*NODE_W-1:0] OWNER_MAP =
    (MAX_SLOTS*NODE_W)'(tdma_pkg::ident_map(MAX_SLOTS, NODE_W)),
  localparam int SLOT_IDX_W  = (MAX_SLOTS  > 1) ? $clog2(MAX_SLOTS)  : 1,
  localparam int ROUND_IDX_W = (MAX_ROUNDS > 1) ? $clog2(MAX_ROUNDS) : 1,
  localparam int SLOT_CNT_W  = $clog2(MAX_SLOTS + 1),
  localparam int ROUND_CNT_W = $clog2(MAX_ROUNDS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run_en,
  input  logic [NODE_W-1:0]      local_id,
  input  logic [LEN_W-1:0]       cfg_slot_len,
  input  logic [SLOT_CNT_W-1:0]  cfg_slots,
  input  logic [ROUND_CNT_W-1:0] cfg_rounds,
  output logic [SLOT_IDX_W-1:0]  slot_idx,
  output logic [ROUND_IDX_W-1:0] round_idx,
  output logic                   tx_en,
  output logic                   slot_start,
  output logic                   round_start,
  output logic                   cycle_start,
  output logic                   cfg_err
);
  logic cfg_ok, active, seq_running, slot_first, slot_end;
  logic slot_wrap, round_wrap, is_mine;

  tdma_cfg_check #(
    .LEN_W(LEN_W), .SLOT_CNT_W(SLOT_CNT_W), .ROUND_CNT_W(ROUND_CNT_W),
    .MAX_SLOTS(MAX_SLOTS), .MAX_ROUNDS(MAX_ROUNDS)
  ) cfg_i (
    .cfg_slot_len(cfg_slot_len), .cfg_slots(cfg_slots),
    .cfg_rounds(cfg_rounds), .cfg_ok(cfg_ok)
  );

  assign active  = run_en && cfg_ok;
  assign cfg_err = !cfg_ok;

  tdma_slot_timer #(.LEN_W(LEN_W)) timer_i (
    .clk(clk), .rst(rst), .active(active), .cfg_slot_len(cfg_slot_len),
    .running(seq_running), .slot_first(slot_first), .slot_end(slot_end)
  );

  tdma_position #(
    .SLOT_IDX_W(SLOT_IDX_W), .ROUND_IDX_W(ROUND_IDX_W),
    .SLOT_CNT_W(SLOT_CNT_W), .ROUND_CNT_W(ROUND_CNT_W)
  ) pos_i (
    .clk(clk), .rst(rst), .active(active), .running(seq_running),
    .slot_end(slot_end), .cfg_slots(cfg_slots), .cfg_rounds(cfg_rounds),
    .slot_q(slot_idx), .round_q(round_idx),
    .slot_wrap(slot_wrap), .round_wrap(round_wrap)
  );

  tdma_owner_lookup #(
    .MAX_SLOTS(MAX_SLOTS), .NODE_W(NODE_W), .SLOT_IDX_W(SLOT_IDX_W),
    .OWNER_MAP(OWNER_MAP)
  ) own_i (
    .slot_idx(slot_idx), .local_id(local_id), .is_mine(is_mine)
  );

  always_comb begin
    tx_en       = seq_running && is_mine;
    slot_start  = slot_first;
    round_start = slot_first && (slot_idx == '0);
    cycle_start = round_start && (round_idx == '0);
  end
endmodule

// File: rtl/tdma_sequencer_chk.sv
module tdma_sequencer_chk #(
  parameter int NODE_W      = 4,
  parameter int SLOT_IDX_W  = 3,
  parameter int ROUND_IDX_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   run_en,
  input logic                   cfg_err,
  input logic [NODE_W-1:0]      local_id,
  input logic                   seq_running,
  input logic                   slot_end,
  input logic                   slot_wrap,
  input logic                   round_wrap,
  input logic                   slot_start,
  input logic                   round_start,
  input logic                   cycle_start,
  input logic                   tx_en,
  input logic [SLOT_IDX_W-1:0]  slot_idx,
  input logic [ROUND_IDX_W-1:0] round_idx
);
  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !seq_running |-> (slot_idx == '0) && (round_idx == '0) && !tx_en && !slot_start);

  // R2
  first_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !cfg_err && !seq_running) |=> (slot_start && round_start && cycle_start));

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_running && !slot_end) |=> (!seq_running || !slot_start));

  // R4
  slot_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_running && slot_end && !slot_wrap) |=> (!seq_running || (slot_start && !round_start)));

  // R5
  cycle_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_running && slot_end && slot_wrap && round_wrap) |=> (!seq_running || cycle_start));

  // R6
  tx_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_running && !slot_end && $stable(local_id)) |=> (!seq_running || $stable(tx_en)));

  // R8
  refused_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !seq_running);

  // R10
  drop_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !seq_running);
endmodule

bind tdma_sequencer tdma_sequencer_chk #(
  .NODE_W(NODE_W), .SLOT_IDX_W(SLOT_IDX_W), .ROUND_IDX_W(ROUND_IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .run_en(run_en), .cfg_err(cfg_err), .local_id(local_id),
  .seq_running(seq_running), .slot_end(slot_end), .slot_wrap(slot_wrap),
  .round_wrap(round_wrap), .slot_start(slot_start), .round_start(round_start),
  .cycle_start(cycle_start), .tx_en(tx_en), .slot_idx(slot_idx), .round_idx(round_idx)
);

// File: tb/tdma_sequencer_tb_top.sv
module tdma_sequencer_tb_top;
  localparam int NW = 4;
  localparam int NSL = 8;
  localparam int NRD = 8;

  function automatic int owner_of(int s);
    case (s)
      0: return 5; 1: return 2; 2: return 7; 3: return 0;
      4: return 3; 5: return 6; 6: return 1; default: return 4;
    endcase
  endfunction

  function automatic logic [NSL*NW-1:0] build_map();
    logic [NSL*NW-1:0] m;
    for (int s = 0; s < NSL; s++) m[s*NW +: NW] = NW'(owner_of(s));
    return m;
  endfunction

  localparam logic [NSL*NW-1:0] MAP = build_map();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [NW-1:0] my_id = 4'd5;
  logic [15:0] len = 16'd4;
  logic [3:0] nslots = 4'd8;
  logic [3:0] nrounds = 4'd3;
  logic [2:0] slot_idx, round_idx;
  logic tx_en, slot_start, round_start, cycle_start, cfg_err;
  logic [NSL-1:0] peer_tx;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;
  int m_run = 0, m_tick = 0, m_slot = 0, m_round = 0;

  always #4 clk = ~clk;

  tdma_sequencer #(.NODE_W(NW), .LEN_W(16), .MAX_SLOTS(NSL), .MAX_ROUNDS(NRD),
                   .OWNER_MAP(MAP)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .local_id(my_id),
    .cfg_slot_len(len), .cfg_slots(nslots), .cfg_rounds(nrounds),
    .slot_idx(slot_idx), .round_idx(round_idx), .tx_en(tx_en),
    .slot_start(slot_start), .round_start(round_start),
    .cycle_start(cycle_start), .cfg_err(cfg_err)
  );

  for (genvar g = 0; g < NSL; g++) begin : g_peer
    logic [2:0] p_slot, p_round;
    logic p_ss, p_rs, p_cs, p_err;
    tdma_sequencer #(.NODE_W(NW), .LEN_W(16), .MAX_SLOTS(NSL), .MAX_ROUNDS(NRD),
                     .OWNER_MAP(MAP)) peer_i (
      .clk(clk), .rst(rst), .run_en(run_en), .local_id(NW'(g)),
      .cfg_slot_len(len), .cfg_slots(nslots), .cfg_rounds(nrounds),
      .slot_idx(p_slot), .round_idx(p_round), .tx_en(peer_tx[g]),
      .slot_start(p_ss), .round_start(p_rs), .cycle_start(p_cs), .cfg_err(p_err)
    );
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit cfg_valid();
    return nslots >= 4 && nslots <= NSL && nrounds >= 1 && nrounds <= NRD && len >= 1;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (rst || !run_en || !cfg_valid()) begin
      m_run = 0; m_tick = 0; m_slot = 0; m_round = 0;
    end else if (m_run == 0) begin
      m_run = 1;
    end else begin
      m_tick++;
      if (m_tick >= len) begin
        m_tick = 0; m_slot++;
        if (m_slot >= nslots) begin
          m_slot = 0; m_round++;
          if (m_round >= nrounds) m_round = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      automatic bit ss = (m_run != 0) && m_tick == 0;
      automatic bit rs = ss && m_slot == 0;
      automatic bit cs = rs && m_round == 0;
      automatic bit tx = (m_run != 0) && owner_of(m_slot) == int'(my_id);
      automatic string tg = (m_run != 0) ? "" : "R1 ";
      chk(int'(slot_idx) == m_slot, {tg, "R4"}, "slot_idx", slot_idx, m_slot);
      chk(int'(round_idx) == m_round, {tg, "R5"}, "round_idx", round_idx, m_round);
      chk(slot_start == ss, {tg, "R3"}, "slot_start", slot_start, ss);
      chk(round_start == rs, {tg, "R4"}, "round_start", round_start, rs);
      chk(cycle_start == cs, {tg, "R5"}, "cycle_start", cycle_start, cs);
      chk(tx_en == tx, {tg, "R6"}, "tx_en", tx_en, tx);
      chk(cfg_err == !cfg_valid(), "R8", "cfg_err", cfg_err, !cfg_valid());
      if (m_run != 0)
        chk($countones(peer_tx) == 1, "R7", "tx owners", $countones(peer_tx), 1);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    logic [8:0] trace[$];
    int cyc_len;
    step(1);
    cmp_on = 1;
    step(2);
    @(negedge clk);
    chk(slot_idx == 0 && !tx_en && !slot_start && !cycle_start, "R1", "reset idle", tx_en, 0);
    step(0); rst = 0;
    step(2);
    @(negedge clk);
    chk(!slot_start && slot_idx == 0, "R1", "disabled idle", slot_start, 0);

    // R2 and R9: three cluster cycles of 8 slots x 3 rounds x 4 cycles
    step(0); run_en = 1;
    cyc_len = 4 * 8 * 3;
    @(posedge clk);
    for (int i = 0; i < 3 * cyc_len; i++) begin
      @(negedge clk);
      trace.push_back({slot_idx, round_idx, tx_en, slot_start, cycle_start});
    end
    chk(trace[0][1] && trace[0][0] && trace[0][8:6] == 0, "R2", "first slot markers",
        int'(trace[0][1:0]), 3);
    for (int i = 0; i < cyc_len; i++) begin
      chk(trace[i] == trace[i + cyc_len], "R9", "cycle 2 vs 1", trace[i + cyc_len], trace[i]);
      chk(trace[i] == trace[i + 2*cyc_len], "R9", "cycle 3 vs 1", trace[i + 2*cyc_len], trace[i]);
    end

    // minimum round, slot length 1
    step(1); run_en = 0;
    step(1); nslots = 4; nrounds = 2; len = 1; run_en = 1;
    step(40);

    // refused configurations while enabled (R8)
    for (int k = 0; k < 5; k++) begin
      step(0);
      case (k)
        0: begin nslots = 3; nrounds = 1; len = 2; end
        1: begin nslots = 9; nrounds = 1; len = 2; end
        2: begin nslots = 4; nrounds = 0; len = 2; end
        3: begin nslots = 4; nrounds = 9; len = 2; end
        default: begin nslots = 4; nrounds = 1; len = 0; end
      endcase
      @(negedge clk);
      chk(cfg_err == 1'b1, "R8", "refused flag", cfg_err, 1);
      @(negedge clk);
      chk(!slot_start && !tx_en && slot_idx == 0, "R8", "held idle", slot_start, 0);
      step(3);
      nslots = 5; nrounds = 8; len = 3;
      step(4);
    end

    // mid-run enable drop and restart (R10)
    step(23); run_en = 0;
    @(posedge clk); @(negedge clk);
    chk(slot_idx == 0 && round_idx == 0 && !slot_start && !tx_en, "R10", "dropped idle",
        slot_idx, 0);
    step(0); run_en = 1;
    @(posedge clk); @(negedge clk);
    chk(cycle_start && slot_idx == 0, "R10", "restart at round 0", cycle_start, 1);
    step(130);

    // reset mid-run
    rst = 1; step(2); rst = 0;
    step(30);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule